// File: doc/BRIEF.md
# Rotating-Priority Interrupt Arbiter

The arbiter decides whether one of eight interrupt lines should interrupt the processor now, and which line. It looks at three vectors: the lines that are pending, the lines that are masked, and the lines already in service. The eight lines are ranked by a priority order that a 3-bit offset can rotate. Priority level `p` belongs to line `(p + offset) mod 8`, and level 0 is the strongest.

The best pending, unmasked line is compared with the strongest line still in service. A new request is raised only if it strictly outranks that line. Two settings change which in-service lines take part in the comparison. With the special-mask setting on, masked in-service lines do not count. With the nested-cascade setting on, in an instance marked as master, the cascade line (line 2) does not count.

The block also reports the strongest line in the raw in-service vector, so that end-of-interrupt logic knows which bit to clear. All outputs are registered and show the inputs sampled at the previous rising clock edge. The request output comes from a two-state register:

- `ST_QUIET`: no request.
- `ST_SIGNAL`: request raised.

At every edge the next state is chosen the same way from either state:

- **grant**: go to `ST_SIGNAL` when the winner test passes.
- **drop**: go to `ST_QUIET` when it fails.

Reset puts the block in `ST_QUIET`.

Top module: `rpa_arbiter`

## Requirements
- R1: While `rst_n` is low, `irq_o`, `irq_num_o`, `svc_valid_o` and `svc_num_o` are all 0, whatever the inputs are.
- R2: If `pend_i & ~mask_i` is zero, `irq_o` is 0 in the next cycle.
- R3: Priority level p (0 is the strongest) maps to line `(p + offset_i) mod 8`. When a request is raised, `irq_num_o` is the line with the lowest level among the bits of `pend_i & ~mask_i`.
- R4: A request is raised only when the candidate's level is strictly lower than the level of the strongest counted in-service line. An equal or higher level raises nothing.
- R5: If no in-service line counts, any unmasked pending line raises `irq_o`.
- R6: With `spec_mask_i` = 1, in-service lines that are masked in `mask_i` do not count. With `spec_mask_i` = 0, they count.
- R7: When `is_master_i` = 1 and `nest_i` = 1, in-service bit 2 does not count. If either input is 0, bit 2 counts.
- R8: `svc_valid_o` is 1 exactly when `insvc_i` is nonzero. `svc_num_o` is the lowest-level set bit of the unfiltered `insvc_i` under the rotation of R3, or 0 when `insvc_i` is zero.
- R9: Each output shows the inputs sampled at the previous rising edge of `clk`, with exactly one register of delay.
- R10: `irq_num_o` is 0 whenever `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 8 | Pending request vector |
| mask_i | input | 8 | Mask vector; 1 blocks the line |
| insvc_i | input | 8 | In-service vector |
| offset_i | input | 3 | Rotation offset; level 0 belongs to this line |
| spec_mask_i | input | 1 | Ignore masked in-service lines |
| nest_i | input | 1 | Nested-cascade setting |
| is_master_i | input | 1 | This instance is the master |
| irq_o | output | 1 | Interrupt request (registered) |
| irq_num_o | output | 3 | Winning line, 0 when no request |
| svc_valid_o | output | 1 | Some line is in service |
| svc_num_o | output | 3 | Strongest in-service line for end-of-interrupt |

## Verification
The assertions take for granted that every input is stable and defined at each rising edge. They also assume the inputs may change freely from one cycle to the next, since the block holds no state other than its output registers. The bench changes inputs only on the falling edge and reads outputs one full cycle later, so each sampled vector meets these assumptions. The stimulus includes every pending vector at every offset, every pending and in-service pair at one offset, and a long pseudo-random run that switches the mask, special-mask, nested-cascade and master inputs.

// File: rtl/rpa_pkg.sv
package rpa_pkg;

    localparam int RPA_LINES   = 8;
    localparam int RPA_CASCADE = 2;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_SIGNAL = 1'b1
    } rpa_state_e;

endpackage

// File: rtl/rpa_prio_search.sv
module rpa_prio_search #(
    parameter int LINES = 8,
    localparam int IW = $clog2(LINES)
) (
    input  logic [LINES-1:0] vec_i,
    input  logic [IW-1:0]    off_i,
    output logic [IW:0]      level_o
);

    localparam logic [IW:0] LVL_NONE = (IW + 1)'(LINES);

    logic [LINES-1:0] rot;

    // rot[p] is the line that sits at priority level p
    for (genvar gp = 0; gp < LINES; gp++) begin : g_rot
        logic [IW-1:0] idx;
        assign idx     = IW'(gp) + off_i;
        assign rot[gp] = vec_i[idx];
    end

    always_comb begin
        level_o = LVL_NONE;
        for (int p = LINES - 1; p >= 0; p--) begin
            if (rot[p]) begin
                level_o = (IW + 1)'(p);
            end
        end
    end

    // R2/R3 guards: an empty vector gives the none code; a found level hits a set line
    always_comb begin
        a_r2_none_code : assert ((vec_i == '0) == (level_o == LVL_NONE));
        if (level_o != LVL_NONE) begin
            a_r3_level_hits : assert (vec_i[level_o[IW-1:0] + off_i]);
        end
    end

endmodule

// File: rtl/rpa_service_filter.sv
module rpa_service_filter #(
    parameter int LINES        = 8,
    parameter int CASCADE_LINE = 2
) (
    input  logic [LINES-1:0] insvc_i,
    input  logic [LINES-1:0] mask_i,
    input  logic             spec_mask_i,
    input  logic             nest_i,
    input  logic             is_master_i,
    output logic [LINES-1:0] eff_o
);

    logic [LINES-1:0] cascade_hole;

    always_comb begin
        cascade_hole = '0;
        if (is_master_i && nest_i) begin
            cascade_hole[CASCADE_LINE] = 1'b1;
        end
    end

    always_comb begin
        eff_o = insvc_i & ~cascade_hole;
        if (spec_mask_i) begin
            eff_o = eff_o & ~mask_i;
        end
    end

    always_comb begin
        a_r6_subset : assert ((eff_o & ~insvc_i) == '0);
        if (spec_mask_i) begin
            a_r6_masked_gone : assert ((eff_o & mask_i) == '0);
        end
        if (is_master_i && nest_i) begin
            a_r7_cascade_gone : assert (!eff_o[CASCADE_LINE]);
        end
    end

endmodule

// File: rtl/rpa_arbiter.sv
module rpa_arbiter
    import rpa_pkg::*;
#(
    parameter int LINES        = RPA_LINES,
    parameter int CASCADE_LINE = RPA_CASCADE,
    localparam int IW = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pend_i,
    input  logic [LINES-1:0] mask_i,
    input  logic [LINES-1:0] insvc_i,
    input  logic [IW-1:0]    offset_i,
    input  logic             spec_mask_i,
    input  logic             nest_i,
    input  logic             is_master_i,
    output logic             irq_o,
    output logic [IW-1:0]    irq_num_o,
    output logic             svc_valid_o,
    output logic [IW-1:0]    svc_num_o
);

    localparam logic [IW:0] LVL_NONE = (IW + 1)'(LINES);

    logic [LINES-1:0] req_vec;
    logic [LINES-1:0] eff_svc;
    logic [IW:0]      cand_lvl;
    logic [IW:0]      cur_lvl;
    logic [IW:0]      svc_lvl;
    logic [IW-1:0]    cand_irq;
    logic [IW-1:0]    svc_irq;
    logic             win;

    rpa_state_e state_q;
    rpa_state_e state_d;
    logic [IW-1:0] irq_num_q;
    logic          svc_valid_q;
    logic [IW-1:0] svc_num_q;

    assign req_vec = pend_i & ~mask_i;

    rpa_service_filter #(
        .LINES       (LINES),
        .CASCADE_LINE(CASCADE_LINE)
    ) filt_i (
        .insvc_i    (insvc_i),
        .mask_i     (mask_i),
        .spec_mask_i(spec_mask_i),
        .nest_i     (nest_i),
        .is_master_i(is_master_i),
        .eff_o      (eff_svc)
    );

    rpa_prio_search #(.LINES(LINES)) cand_srch_i (
        .vec_i  (req_vec),
        .off_i  (offset_i),
        .level_o(cand_lvl)
    );

    rpa_prio_search #(.LINES(LINES)) cur_srch_i (
        .vec_i  (eff_svc),
        .off_i  (offset_i),
        .level_o(cur_lvl)
    );

    rpa_prio_search #(.LINES(LINES)) svc_srch_i (
        .vec_i  (insvc_i),
        .off_i  (offset_i),
        .level_o(svc_lvl)
    );

    assign cand_irq = cand_lvl[IW-1:0] + offset_i;
    assign svc_irq  = svc_lvl[IW-1:0] + offset_i;

    // none code equals LINES, so an absent candidate never passes the strict test
    assign win = (cand_lvl < cur_lvl);

    always_comb begin
        state_d = ST_QUIET;
        unique case (state_q)
            ST_QUIET:  state_d = win ? ST_SIGNAL : ST_QUIET;
            ST_SIGNAL: state_d = win ? ST_SIGNAL : ST_QUIET;
            default:   state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_num_q   <= '0;
            svc_valid_q <= 1'b0;
            svc_num_q   <= '0;
        end else begin
            irq_num_q   <= win ? cand_irq : '0;
            svc_valid_q <= (svc_lvl != LVL_NONE);
            svc_num_q   <= (svc_lvl != LVL_NONE) ? svc_irq : '0;
        end
    end

    assign irq_o       = (state_q == ST_SIGNAL);
    assign irq_num_o   = irq_num_q;
    assign svc_valid_o = svc_valid_q;
    assign svc_num_o   = svc_num_q;

    a_r2_no_candidate : assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_i & ~mask_i) == '0) |=> !irq_o);

    a_r5_idle_service : assert property (@(posedge clk) disable iff (!rst_n)
        (((pend_i & ~mask_i) != '0) && (insvc_i == '0)) |=> irq_o);

    a_r4_top_busy : assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_i[offset_i] && !spec_mask_i && !nest_i) |=> !irq_o);

    a_r3_winner_pending : assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((($past(pend_i & ~mask_i) >> irq_num_o) & LINES'(1)) != '0));

    a_r10_num_idle : assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (irq_num_o == '0));

    a_r8_svc_empty : assert property (@(posedge clk) disable iff (!rst_n)
        (insvc_i == '0) |=> (!svc_valid_o && svc_num_o == '0));

    a_r1_reset_quiet : assert property (@(posedge clk)
        !rst_n |-> (!irq_o && !svc_valid_o));

endmodule

// File: tb/rpa_arbiter_tb_top.sv
module rpa_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pend_i = '0;
    logic [7:0] mask_i = '0;
    logic [7:0] insvc_i = '0;
    logic [2:0] offset_i = '0;
    logic       spec_mask_i = 1'b0;
    logic       nest_i = 1'b0;
    logic       is_master_i = 1'b0;
    logic       irq_o;
    logic [2:0] irq_num_o;
    logic       svc_valid_o;
    logic [2:0] svc_num_o;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    rpa_arbiter dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .pend_i     (pend_i),
        .mask_i     (mask_i),
        .insvc_i    (insvc_i),
        .offset_i   (offset_i),
        .spec_mask_i(spec_mask_i),
        .nest_i     (nest_i),
        .is_master_i(is_master_i),
        .irq_o      (irq_o),
        .irq_num_o  (irq_num_o),
        .svc_valid_o(svc_valid_o),
        .svc_num_o  (svc_num_o)
    );

    function automatic int lvl_of(input logic [7:0] v, input logic [2:0] o);
        for (int p = 0; p < 8; p++) begin
            if (v[(p + o) % 8]) return p;
        end
        return 8;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_vec(input logic [7:0] p, input logic [7:0] m, input logic [7:0] s,
                           input logic [2:0] o, input logic sm, input logic nm,
                           input logic ms, input string tag);
        logic [7:0] eff;
        int cand;
        int cur;
        int sl;
        logic ewin;
        int enum_v;
        pend_i = p; mask_i = m; insvc_i = s; offset_i = o;
        spec_mask_i = sm; nest_i = nm; is_master_i = ms;
        @(posedge clk);
        @(negedge clk);
        cand = lvl_of(p & ~m, o);
        eff = s;
        if (sm) eff = eff & ~m;
        if (ms && nm) eff[2] = 1'b0;
        cur = lvl_of(eff, o);
        ewin = (cand < cur);
        enum_v = ewin ? ((cand + o) % 8) : 0;
        sl = lvl_of(s, o);
        check(tag, {irq_o, irq_num_o}, {ewin, enum_v[2:0]});
        check("R8", {svc_valid_o, svc_num_o},
              {(s != 0), (s != 0) ? 3'((sl + o) % 8) : 3'd0});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 200000) begin
                failures++;
                $display("FAIL R9 watchdog actual=%0d expected<=200000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] lf;
        // R1: reset holds outputs low even with busy inputs
        pend_i = 8'hFF; insvc_i = 8'h0F;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", {irq_o, irq_num_o, svc_valid_o, svc_num_o}, 0);
        rst_n = 1'b1;
        pend_i = '0; insvc_i = '0;
        @(negedge clk);

        // R9: output holds until the next rising edge
        run_vec(8'h01, 0, 0, 0, 0, 0, 0, "R5");
        pend_i = 8'h00;
        #1;
        check("R9", irq_o, 1);
        @(posedge clk);
        @(negedge clk);
        check("R9", irq_o, 0);

        // R3 rotation directed cases
        run_vec(8'h81, 0, 0, 3'd0, 0, 0, 0, "R3");
        run_vec(8'h81, 0, 0, 3'd7, 0, 0, 0, "R3");
        run_vec(8'h81, 0, 0, 3'd1, 0, 0, 0, "R3");
        run_vec(8'h81, 8'h80, 0, 3'd7, 0, 0, 0, "R2");
        run_vec(8'hFF, 8'hFF, 0, 3'd0, 0, 0, 0, "R2");
        // R4 strict comparison
        run_vec(8'h08, 0, 8'h08, 0, 0, 0, 0, "R4");
        run_vec(8'h04, 0, 8'h08, 0, 0, 0, 0, "R4");
        run_vec(8'h10, 0, 8'h08, 0, 0, 0, 0, "R4");
        run_vec(8'h01, 0, 8'h80, 3'd7, 0, 0, 0, "R4");
        // R6 special mask
        run_vec(8'h10, 8'h01, 8'h01, 0, 0, 0, 0, "R6");
        run_vec(8'h10, 8'h01, 8'h01, 0, 1, 0, 0, "R6");
        // R7 cascade exclusion
        run_vec(8'h08, 0, 8'h04, 0, 0, 1, 1, "R7");
        run_vec(8'h08, 0, 8'h04, 0, 0, 1, 0, "R7");
        run_vec(8'h08, 0, 8'h04, 0, 0, 0, 1, "R7");

        // R3 / R10: every pending vector at every offset
        for (int oi = 0; oi < 8; oi++) begin
            for (int pi = 0; pi < 256; pi++) begin
                run_vec(pi[7:0], 0, 0, oi[2:0], 0, 0, 0, "R3");
            end
        end
        // R4: every pending and in-service pair at one offset
        for (int pi = 0; pi < 256; pi++) begin
            for (int si = 0; si < 256; si++) begin
                run_vec(pi[7:0], 0, si[7:0], 3'd3, 0, 0, 0, "R4");
            end
        end
        // R6 R7 R10 mixed pseudo-random run
        lf = 32'h1234_5678;
        for (int k = 0; k < 20000; k++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            run_vec(lf[7:0], lf[15:8] & lf[31:24], lf[23:16], lf[26:24],
                    lf[27], lf[28], lf[29], "R10");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule